// File: doc/BRIEF.md
# Glitch-free dual-polarity clock gate

This block gates a free-running clock with an enable request. It either passes the clock or holds the output at a fixed level. It never shortens a high phase or a low phase of the clock it passes. The polarity is fixed when the block is built.

- In the AND style the output rests low while the clock is blocked.
- In the OR style the output rests high while the clock is blocked.

The request is retimed into an internal enable flop before it reaches the gate. The flop uses the clock edge that starts the phase in which the gate is blind to its enable input:

- The AND style samples on the falling edge.
- The OR style samples on the rising edge.

A test-mode input forces the clock through. It goes through the same retiming flop, so switching test mode on or off is also glitch-free. An active-low asynchronous reset clears the internal enable, and the output then parks at its resting level.

Top module: `clk_gate_dual`

## Requirements
- R1: With GATE_TYPE = 0 (AND style), `clk_o` is high only during a high phase of `clk_i` while the internal enable is set. Otherwise it is 0.
- R2: In the AND style the internal enable changes only at a falling edge of `clk_i`. A request change during a high phase therefore neither starts nor ends an output pulse within that phase.
- R3: With GATE_TYPE = 1 (OR style), `clk_o` is low only during a low phase of `clk_i` while the internal enable is set. Otherwise it is 1.
- R4: In the OR style the internal enable changes only at a rising edge of `clk_i`. A request change during a low phase therefore neither starts nor ends an output low pulse within that phase.
- R5: Every passed pulse keeps its full width:
  - In the AND style, every output high phase lasts exactly half a clock period, and every output low phase lasts a whole number of half periods.
  - In the OR style, every output low phase lasts exactly half a period, and every output high phase lasts a whole number of half periods.
- R6: While `rst_ni` is low, the internal enable is cleared and `clk_o` sits at its resting level (0 for AND, 1 for OR), whatever `en_i` and `test_en_i` are.
- R7: A high `test_en_i` sets the internal enable at the next retiming edge, even with `en_i` low. The clock then passes exactly as for a normal enable.
- R8: An asserted request is captured at the first retiming edge after it changes. The first full output pulse then starts at the next edge of the opposite sense:
  - AND style: capture on a fall, first high pulse on the following rise.
  - OR style: capture on a rise, first low pulse on the following fall.
- R9: When the request drops, the pulse already in progress completes. The next phase of the clock is still passed up to the retiming edge. No further pulse follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock-enable request, active high |
| test_en_i | input | 1 | Test-mode override, forces the clock through |
| clk_o | output | 1 | Gated clock |

## Verification
The assertions assume the following about the inputs:
- `en_i` and `test_en_i` never change within setup or hold distance of a `clk_i` edge.
- `rst_ni` is released away from a clock edge.

The bench keeps to this. It moves the request only at a random offset of 1 to 4 ns into a 5 ns phase, and it releases reset in mid-phase. An asynchronous reset can cut short a pulse that is in progress. For that reason the pulse-width monitor is switched off around the mid-run reset and resumes from the next output edge.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int unsigned GATE_AND = 0;
  localparam int unsigned GATE_OR  = 1;

  // output level while the clock is blocked
  function automatic logic park_level(input int unsigned gate_type);
    return gate_type == GATE_OR;
  endfunction
endpackage

// File: rtl/clk_gate_retime.sv
module clk_gate_retime #(
  parameter int unsigned GATE_TYPE = clk_gate_pkg::GATE_AND
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o
);
  logic en_q;

  generate
    if (GATE_TYPE == clk_gate_pkg::GATE_AND) begin : g_fall
      // update only while the AND gate is masked (clock low)
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= req_i;
      end
    end else begin : g_rise
      // update only while the OR gate is masked (clock high)
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= req_i;
      end
    end
  endgenerate

  assign en_o = en_q;
endmodule

// File: rtl/clk_gate_comb.sv
module clk_gate_comb #(
  parameter int unsigned GATE_TYPE = clk_gate_pkg::GATE_AND
) (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  generate
    if (GATE_TYPE == clk_gate_pkg::GATE_AND) begin : g_and
      assign clk_o = clk_i & en_i;
    end else begin : g_or
      assign clk_o = clk_i | ~en_i;
    end
  endgenerate
endmodule

// File: rtl/clk_gate_dual.sv
module clk_gate_dual #(
  parameter int unsigned GATE_TYPE = clk_gate_pkg::GATE_AND
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic test_en_i,
  output logic clk_o
);
  logic gate_req;
  logic gate_en_q;

  assign gate_req = en_i | test_en_i;

  clk_gate_retime #(.GATE_TYPE(GATE_TYPE)) u_retime (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (gate_req),
    .en_o   (gate_en_q)
  );

  clk_gate_comb #(.GATE_TYPE(GATE_TYPE)) u_gate (
    .clk_i (clk_i),
    .en_i  (gate_en_q),
    .clk_o (clk_o)
  );
endmodule

// File: rtl/clk_gate_dual_chk.sv
module clk_gate_dual_chk #(
  parameter int unsigned GATE_TYPE = clk_gate_pkg::GATE_AND
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic test_en_i,
  input logic clk_o,
  input logic en_q
);
  logic req;
  logic en_mid;
  logic park;

  assign req  = en_i | test_en_i;
  assign park = clk_gate_pkg::park_level(GATE_TYPE);

  generate
    if (GATE_TYPE == clk_gate_pkg::GATE_AND) begin : g_and
      // enable seen at the rise, compared at the following fall
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_mid <= 1'b0;
        else         en_mid <= en_q;
      end

      assert_en_hold_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
        en_q == en_mid);
      assert_park_R1: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !en_q |-> clk_o == park);
      assert_req_on_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
        req |=> en_q);
      assert_req_off_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !req |=> !en_q);
      assert_test_force_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
        test_en_i |=> en_q);
    end else begin : g_or
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_mid <= 1'b0;
        else         en_mid <= en_q;
      end

      assert_en_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q == en_mid);
      assert_park_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |-> clk_o == park);
      assert_req_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req |=> en_q);
      assert_req_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req |=> !en_q);
      assert_test_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        test_en_i |=> en_q);
    end
  endgenerate

  assert_reset_clear_R6: assert property (@(posedge clk_i)
    !rst_ni |-> !en_q);
endmodule

bind clk_gate_dual clk_gate_dual_chk #(.GATE_TYPE(GATE_TYPE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .test_en_i (test_en_i),
  .clk_o     (clk_o),
  .en_q      (gate_en_q)
);

// File: tb/clk_gate_dual_tb_top.sv
`timescale 1ns/100ps
module clk_gate_dual_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_T     = CLK_PERIOD * 5; // half period in 0.1 ns

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic test_en;
  logic and_clk;
  logic or_clk;

  int checks   = 0;
  int failures = 0;
  bit mon_on   = 1'b0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  clk_gate_dual #(.GATE_TYPE(0)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .test_en_i (test_en), .clk_o (and_clk)
  );

  clk_gate_dual #(.GATE_TYPE(1)) dut_or_i (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .test_en_i (test_en), .clk_o (or_clk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  // pulse width monitors (R5)
  realtime and_last, or_last;
  bit and_have, or_have;

  task automatic mon_start();
    and_have = 1'b0;
    or_have  = 1'b0;
    mon_on   = 1'b1;
  endtask

  always @(and_clk) begin
    if (mon_on) begin
      if (!and_have) begin
        and_have = 1'b1;
      end else begin
        int wt;
        wt = int'(($realtime - and_last) * 10.0);
        checks++;
        if (and_clk === 1'b0 ? (wt != HALF_T) : (wt % HALF_T != 0 || wt == 0)) begin
          failures++;
          $display("FAIL R5 AND width at %0t: got %0d expected %s%0d (0.1ns)", $time, wt,
                   and_clk === 1'b0 ? "" : "multiple of ", HALF_T);
        end
      end
      and_last = $realtime;
    end
  end

  always @(or_clk) begin
    if (mon_on) begin
      if (!or_have) begin
        or_have = 1'b1;
      end else begin
        int wt;
        wt = int'(($realtime - or_last) * 10.0);
        checks++;
        if (or_clk === 1'b1 ? (wt != HALF_T) : (wt % HALF_T != 0 || wt == 0)) begin
          failures++;
          $display("FAIL R5 OR width at %0t: got %0d expected %s%0d (0.1ns)", $time, wt,
                   or_clk === 1'b1 ? "" : "multiple of ", HALF_T);
        end
      end
      or_last = $realtime;
    end
  end

  task automatic drive_req(input bit use_test, input logic v);
    if (use_test) test_en = v;
    else          en      = v;
  endtask

  // R6: reset holds both styles at their resting level
  task automatic t_reset_park();
    en = 1'b1; test_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2; chk("R6 and reset park", and_clk, 1'b0);
      @(negedge clk); #2; chk("R6 or reset park", or_clk, 1'b1);
    end
    en = 1'b0; test_en = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2; chk("R1 and parked after reset", and_clk, 1'b0);
    @(negedge clk); #2; chk("R3 or parked after reset", or_clk, 1'b1);
  endtask

  // R2 R4 R7 R8: request rises within a high or a low phase
  task automatic t_enable_on(input bit high_phase, input bit use_test, input int off);
    if (high_phase) begin
      @(posedge clk); #(off) drive_req(use_test, 1'b1);
      #0.5 chk("R2 and no pulse change mid-high", and_clk, 1'b0);
      @(negedge clk); #2 chk("R4 or not yet captured", or_clk, 1'b1);
      chk("R1 and low phase", and_clk, 1'b0);
      @(posedge clk); #2 chk(use_test ? "R7 and test pulse" : "R8 and first pulse", and_clk, 1'b1);
      @(negedge clk); #2 chk(use_test ? "R7 or test pulse" : "R8 or first pulse", or_clk, 1'b0);
      chk("R1 and low phase", and_clk, 1'b0);
    end else begin
      @(negedge clk); #(off) drive_req(use_test, 1'b1);
      #0.5 chk("R4 or no pulse change mid-low", or_clk, 1'b1);
      @(posedge clk); #2 chk("R2 and not yet captured", and_clk, 1'b0);
      chk("R3 or high phase", or_clk, 1'b1);
      @(negedge clk); #2 chk(use_test ? "R7 or test pulse" : "R8 or first pulse", or_clk, 1'b0);
      chk("R1 and low phase", and_clk, 1'b0);
      @(posedge clk); #2 chk(use_test ? "R7 and test pulse" : "R8 and first pulse", and_clk, 1'b1);
    end
  endtask

  // R9: request falls; pulse in progress completes, then park
  task automatic t_enable_off(input bit high_phase, input bit use_test, input int off);
    if (high_phase) begin
      @(posedge clk); #(off) drive_req(use_test, 1'b0);
      #0.5 chk("R9 and pulse completes", and_clk, 1'b1);
      @(negedge clk); #2 chk("R9 or still passes", or_clk, 1'b0);
      chk("R9 and parked", and_clk, 1'b0);
      @(posedge clk); #2 chk("R9 and stays parked", and_clk, 1'b0);
      chk("R9 or parked", or_clk, 1'b1);
      @(negedge clk); #2 chk("R9 or stays parked", or_clk, 1'b1);
    end else begin
      @(negedge clk); #(off) drive_req(use_test, 1'b0);
      #0.5 chk("R9 or pulse completes", or_clk, 1'b0);
      @(posedge clk); #2 chk("R9 and still passes", and_clk, 1'b1);
      @(negedge clk); #2 chk("R9 or parked", or_clk, 1'b1);
      chk("R9 and parked", and_clk, 1'b0);
      @(posedge clk); #2 chk("R9 and stays parked", and_clk, 1'b0);
    end
    repeat (2) @(posedge clk);
  endtask

  // R6: asynchronous reset while both gates are running
  task automatic t_mid_reset();
    en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2 mon_on = 1'b0; rst_n = 1'b0;
    @(posedge clk); #2 chk("R6 and reset mid-run", and_clk, 1'b0);
    @(negedge clk); #2 chk("R6 or reset mid-run", or_clk, 1'b1);
    @(posedge clk); #2 chk("R6 and reset ignores en", and_clk, 1'b0);
    en = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    mon_start();
    #2 chk("R1 and parked after mid reset", and_clk, 1'b0);
    @(negedge clk); #2 chk("R3 or parked after mid reset", or_clk, 1'b1);
  endtask

  initial begin
    rst_n = 1'b1; en = 1'b0; test_en = 1'b0;
    #1 rst_n = 1'b0;
    t_reset_park();
    mon_start();
    for (int i = 0; i < 16; i++) begin
      t_enable_on(i[0], i[1], $urandom_range(1, 4));
      repeat (i[3:2]) @(posedge clk);
      t_enable_off(i[2] ^ i[0], i[1], $urandom_range(1, 4));
    end
    t_mid_reset();
    t_enable_on(1'b1, 1'b0, 2);
    t_enable_off(1'b0, 1'b0, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule